// File: doc/BRIEF.md
# Bidirectional Shift Register

This block is a small word register that carries out one of four operations on every rising clock edge. Two select inputs choose the operation. It can keep its contents, move them one place toward the most significant end, move them one place toward the least significant end, or take a new word from a parallel input. Each direction of movement has its own serial input, which fills the bit position left empty by the move. The bit that is pushed out at the far end is lost.

The register is meant to sit in a datapath as a serial-to-parallel or parallel-to-serial stage, or as a staging register that a controller steers one step at a time. The word width is a parameter and defaults to four bits. A synchronous, active-high reset clears the register, and it overrides whatever the select inputs request.

Top module: `bsr_shift_reg`

## Requirements
- R1: While `rst` is high at a rising edge, `word_out` becomes all zeros after that edge, whatever the select, serial and parallel inputs are.
- R2: With `sel_up`=0 and `sel_down`=0 (hold), `word_out` keeps its value across the edge.
- R3: With `sel_up`=1 and `sel_down`=0 (move toward the MSB), the new `word_out` is the old bits [W-2:0] placed in [W-1:1], with `fill_lsb` in bit 0. The old bit W-1 is dropped.
- R4: With `sel_up`=0 and `sel_down`=1 (move toward the LSB), the new `word_out` is the old bits [W-1:1] placed in [W-2:0], with `fill_msb` in bit W-1. The old bit 0 is dropped.
- R5: With `sel_up`=1 and `sel_down`=1 (load), the new `word_out` equals `load_word`.
- R6: Inputs that the selected operation does not use have no effect. Both fill inputs are ignored in hold and load, `load_word` is ignored in hold and in both moves, and a move ignores the fill input of the other direction.
- R7: `word_out` changes only at a rising clock edge. Over any sequence of select and data inputs, each edge applies exactly the one operation chosen by the select bits sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, overrides the selects |
| sel_up | input | 1 | Low select bit; set alone, it moves the word toward the MSB |
| sel_down | input | 1 | High select bit; set alone, it moves the word toward the LSB |
| fill_lsb | input | 1 | Serial bit that enters bit 0 on a move toward the MSB |
| fill_msb | input | 1 | Serial bit that enters bit W-1 on a move toward the LSB |
| load_word | input | W | Parallel data, taken when both select bits are high |
| word_out | output | W | Current register contents |

## Verification
The bench asserts reset while both select bits call for a load, so a design that gave the selects priority over the clear would show the parallel word instead of zero. It shifts patterns whose end bits are set in both directions, with each fill value in turn, to expose a swapped direction, a rotation instead of a discard, or a wrong choice of fill input. It toggles the unused fill and parallel inputs during hold, load and the opposite move, so a mux that leaks an unselected source is caught. It also runs a long random sequence against a cycle model and checks that the output does not move between edges.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    // Select encoding: bit 0 is sel_up, bit 1 is sel_down.
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

    // One-hot source choice for each bit cell.
    typedef struct packed {
        logic keep;
        logic from_lower;
        logic from_upper;
        logic from_par;
    } cell_ctl_t;

    function automatic op_e decode_op(input logic up, input logic down);
        return op_e'({down, up});
    endfunction

    function automatic cell_ctl_t ctl_of(input op_e op);
        cell_ctl_t c;
        c = '0;
        case (op)
            OP_HOLD: c.keep       = 1'b1;
            OP_UP:   c.from_lower = 1'b1;
            OP_DOWN: c.from_upper = 1'b1;
            OP_LOAD: c.from_par   = 1'b1;
            default: c.keep       = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsr_mode_decode.sv
module bsr_mode_decode
    import bsr_pkg::*;
(
    input  logic      sel_up,
    input  logic      sel_down,
    output cell_ctl_t ctl
);
    op_e op;

    always_comb begin
        op  = decode_op(sel_up, sel_down);
        ctl = ctl_of(op);
    end
endmodule

// File: rtl/bsr_bit_cell.sv
module bsr_bit_cell
    import bsr_pkg::*;
(
    input  cell_ctl_t ctl,
    input  logic      cur_bit,
    input  logic      lower_bit,
    input  logic      upper_bit,
    input  logic      par_bit,
    output logic      next_bit
);
    always_comb begin
        next_bit = (ctl.keep       & cur_bit)
                 | (ctl.from_lower & lower_bit)
                 | (ctl.from_upper & upper_bit)
                 | (ctl.from_par   & par_bit);
    end
endmodule

// File: rtl/bsr_shift_reg.sv
module bsr_shift_reg
    import bsr_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_up,
    input  logic         sel_down,
    input  logic         fill_lsb,
    input  logic         fill_msb,
    input  logic [W-1:0] load_word,
    output logic [W-1:0] word_out
);
    localparam int unsigned TOP = W - 1;

    cell_ctl_t    ctl;
    logic [W-1:0] word_q;
    logic [W-1:0] lower_vec;
    logic [W-1:0] upper_vec;
    logic [W-1:0] word_d;

    bsr_mode_decode u_dec (
        .sel_up   (sel_up),
        .sel_down (sel_down),
        .ctl      (ctl)
    );

    // Neighbour seen by each bit: its lower or upper neighbour, or a fill input at the ends.
    assign lower_vec = {word_q[TOP-1:0], fill_lsb};
    assign upper_vec = {fill_msb, word_q[TOP:1]};

    for (genvar i = 0; i < W; i++) begin : g_cell
        bsr_bit_cell u_cell (
            .ctl       (ctl),
            .cur_bit   (word_q[i]),
            .lower_bit (lower_vec[i]),
            .upper_bit (upper_vec[i]),
            .par_bit   (load_word[i]),
            .next_bit  (word_d[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word_out = word_q;

    p_clear_r1: assert property (@(posedge clk)
        rst |=> (word_out == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!sel_up && !sel_down) |=> $stable(word_out));

    p_up_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_up && !sel_down) |=>
            (word_out == {$past(word_out[TOP-1:0]), $past(fill_lsb)}));

    p_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!sel_up && sel_down) |=>
            (word_out == {$past(fill_msb), $past(word_out[TOP:1])}));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_up && sel_down) |=> (word_out == $past(load_word)));

endmodule

// File: tb/bsr_shift_reg_test.sv
module bsr_shift_reg_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_up = 1'b0;
    logic         sel_down = 1'b0;
    logic         fill_lsb = 1'b0;
    logic         fill_msb = 1'b0;
    logic [W-1:0] load_word = '0;
    logic [W-1:0] word_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] model = '0;

    bsr_shift_reg #(.W(W)) uut (
        .clk(clk), .rst(rst), .sel_up(sel_up), .sel_down(sel_down),
        .fill_lsb(fill_lsb), .fill_msb(fill_msb),
        .load_word(load_word), .word_out(word_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] exp);
        n_checks++;
        if (word_out !== exp) begin
            n_fail++;
            $display("FAIL %s: word_out=%b expected=%b", req, word_out, exp);
        end
    endtask

    // One clock: drive inputs after the falling edge, check the output is
    // steady before the rising edge (R7), then check the result after it.
    task automatic step(input string req, input logic r, input logic up,
                        input logic dn, input logic fl, input logic fm,
                        input logic [W-1:0] pw);
        @(negedge clk);
        rst = r; sel_up = up; sel_down = dn;
        fill_lsb = fl; fill_msb = fm; load_word = pw;
        #1;
        check("R7", model);
        if (r)              model = '0;
        else if (up && dn)  model = pw;
        else if (up)        model = {model[W-2:0], fl};
        else if (dn)        model = {fm, model[W-1:1]};
        @(posedge clk);
        #1;
        check(req, model);
    endtask

    task automatic t_reset_r1;
        step("R1", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF);
        step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h9);
        step("R1", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF);
        check("R1", 4'h0);
    endtask

    task automatic t_hold_r2;
        step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hA);
        step("R2", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h5);
        step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
        check("R2", 4'hA);
    endtask

    task automatic t_up_r3;
        step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1001);
        step("R3", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0);
        check("R3", 4'b0011);
        step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF);
        check("R3", 4'b0110);
        step("R3", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0);
        check("R3", 4'b1101);
    endtask

    task automatic t_down_r4;
        step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1001);
        step("R4", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0);
        check("R4", 4'b1100);
        step("R4", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF);
        check("R4", 4'b0110);
        step("R4", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0);
        check("R4", 4'b1011);
    endtask

    task automatic t_load_r5;
        step("R5", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
        check("R5", 4'h0);
        step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF);
        check("R5", 4'hF);
    endtask

    task automatic t_ignored_r6;
        step("R5", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h6);
        step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h9);
        check("R6", 4'h6);
        step("R6", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF);
        check("R6", 4'hC);
        step("R6", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF);
        check("R6", 4'h6);
    endtask

    task automatic t_random_r7;
        for (int k = 0; k < 400; k++) begin
            logic [7:0] rv;
            rv = 8'($urandom);
            step("R7", (k % 97) == 96, rv[0], rv[1], rv[2], rv[3], rv[7:4]);
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_hold_r2();
        t_up_r3();
        t_down_r4();
        t_load_r5();
        t_ignored_r6();
        t_random_r7();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule